// File: doc/BRIEF.md
# Debug Port Command Sequencer

This block is the command engine behind a full-duplex debug link. Each transfer carries one 16-bit word from the host into the block and one 17-bit response word back. The response to a command always comes back in the transfer that follows it, so the host sends the next command while it collects the previous result. Every response word carries a status flag in bit 16. When the flag is set, the word is a status code and not data.

The sequencer collects the operand words of multi-word commands. It keeps a 16-entry register file (data registers 0 to 7, address registers 8 to 15) and four system registers, and it runs sized accesses on a simple request/acknowledge memory bus. Block dump and fill continue from the pointers that earlier reads and writes set up. The block can also pulse a peripheral reset output, and it raises a one-cycle exit strobe for resume and call.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset, the first transfer returns command-complete (17'h0FFFF). `mem_req`, `periph_rst` and `exit_pulse` are low after reset.
- R2: A command word is decoded as follows: opcode in bits 15:12, size in bits 7:6 (0 byte, 1 word, 2 long), register index in bits 3:0. A command's response appears on the following transfer. Opcode 0 (no-op) returns 17'h0FFFF.
- R3: Opcode 2 writes register `index` from two operand words, upper half first. Both operand transfers return not-ready (17'h10000). Opcode 1 reads a register. The transfer that follows the read returns the upper half, and the word received in that transfer is discarded. The transfer after that returns the lower half and is taken as a new command.
- R4: Opcodes 4 and 3 write and read the system registers using index bits 1:0, in the same way as R3. System register 0 is the source function code and register 1 is the destination function code.
- R5: Opcode 5 is a memory read. It takes two address words, upper half first. The access is tagged with bits 2:0 of the source function code, and the request and address stay stable until acknowledge or error. A byte or word result returns as one word, zero-extended. A long result returns as upper half then lower half, as in R3.
- R6: Opcode 6 is a memory write. It takes two address words, then one data word (byte or word size) or two data words (long size). The access is tagged with the destination function code. Completion returns 17'h0FFFF.
- R7: While a memory access is outstanding, every transfer returns not-ready and its incoming word is discarded.
- R8: An opcode from 12 to 15, or size 3 on a memory command, returns illegal (17'h1FFFF) on the next transfer. The word in that next transfer is decoded as a command.
- R9: A bus error on an access returns 17'h10001 on the next transfer, and any remaining result words are dropped.
- R10: Opcode 7 (dump) takes no operand. It reads at the last read/dump address plus 1, 2 or 4, depending on its own size.
- R11: Opcode 8 (fill) takes only data words. It writes at the last write/fill address plus 1, 2 or 4, depending on its own size.
- R12: Opcode 11 drives `periph_rst` high for exactly 512 cycles. The sequencer keeps answering transfers while it is high.
- R13: Opcode 9 (resume) and opcode 10 (call) each raise `exit_pulse` for one cycle and return complete. `exit_call` is high only for call.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_valid | input | 1 | One-cycle strobe marking a link transfer |
| xfer_in | input | 16 | Host word of this transfer |
| resp_out | output | 17 | Response word returned in this transfer |
| mem_req | output | 1 | Memory access request, held until acknowledge or error |
| mem_we | output | 1 | Access is a write |
| mem_size | output | 2 | Access size: 0 byte, 1 word, 2 long |
| mem_fc | output | 3 | Address-space code of the access |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, right-justified |
| mem_ack | input | 1 | Access finished normally |
| mem_berr | input | 1 | Access finished with bus or address error |
| periph_rst | output | 1 | Peripheral reset output |
| exit_pulse | output | 1 | One-cycle strobe for resume or call |
| exit_call | output | 1 | Marks the strobe as a call |

## Verification
Because of the one-transfer lag, a wrong internal state reaches the ports on the very next transfer. A stuck pending flag turns every later response into not-ready. A miscounted operand stage shifts the status and data codes by one transfer. A wrong dump or fill pointer shows up as wrong data one transfer after the dump, or on the next read of the filled location. The bench therefore predicts the exact response of every transfer in long chains that mix commands. It also watches the bus tagging, the reset-pulse length and the strobe count directly.

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq #(
  parameter int RST_CYCLES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_valid,
  input  logic [15:0] xfer_in,
  output logic [16:0] resp_out,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_size,
  output logic [2:0]  mem_fc,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  input  logic        mem_berr,
  output logic        periph_rst,
  output logic        exit_pulse,
  output logic        exit_call
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam logic [16:0] R_OK   = 17'h0FFFF;
  localparam logic [16:0] R_NR   = 17'h10000;
  localparam logic [16:0] R_ILL  = 17'h1FFFF;
  localparam logic [16:0] R_BERR = 17'h10001;

  localparam logic [3:0] OP_NOP = 4'd0, OP_RREG = 4'd1, OP_WREG = 4'd2, OP_RSYS = 4'd3,
                         OP_WSYS = 4'd4, OP_READ = 4'd5, OP_WRITE = 4'd6, OP_DUMP = 4'd7,
                         OP_FILL = 4'd8, OP_GO = 4'd9, OP_CALL = 4'd10, OP_RST = 4'd11;

  typedef enum logic [1:0] {ST_CMD, ST_OPND, ST_BUSY, ST_RESHI} st_t;
  st_t state;

  logic [3:0]  op_q, ix_q;
  logic [1:0]  sz_q;
  logic [2:0]  need;
  logic [1:0]  got;
  logic [15:0] sr, lo_q;
  logic [31:0] addr_lat, rd_ptr, wr_ptr;
  logic [31:0] regs [16];
  logic [31:0] sys  [4];
  logic [16:0] resp_q;
  logic [CW-1:0] rst_cnt;

  logic [3:0]  c_op;
  logic [1:0]  c_sz;
  logic        last;
  logic [31:0] wdat, lword, inc_c, inc_q;

  assign c_op  = xfer_in[15:12];
  assign c_sz  = xfer_in[7:6];
  assign last  = ({1'b0, got} == need - 3'd1);
  assign lword = {sr, xfer_in};
  assign wdat  = (sz_q == 2'd2) ? lword : (sz_q == 2'd1) ? {16'h0, xfer_in} : {24'h0, xfer_in[7:0]};
  assign inc_c = 32'd1 << c_sz;
  assign inc_q = 32'd1 << sz_q;
  assign resp_out   = resp_q;
  assign periph_rst = (rst_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_CMD;
      op_q <= '0; ix_q <= '0; sz_q <= '0; need <= '0; got <= '0;
      sr <= '0; lo_q <= '0; addr_lat <= '0; rd_ptr <= '0; wr_ptr <= '0;
      for (int i = 0; i < 16; i++) regs[i] <= '0;
      for (int i = 0; i < 4; i++) sys[i] <= '0;
      resp_q <= R_OK;
      rst_cnt <= '0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_size <= '0; mem_fc <= '0;
      mem_addr <= '0; mem_wdata <= '0;
      exit_pulse <= 1'b0; exit_call <= 1'b0;
    end else begin
      exit_pulse <= 1'b0;
      if (rst_cnt != '0) rst_cnt <= rst_cnt - CW'(1);
      if (state == ST_BUSY) begin
        if (mem_ack || mem_berr) begin
          mem_req <= 1'b0;
          state   <= ST_CMD;
          if (mem_berr)           resp_q <= R_BERR;
          else if (mem_we)        resp_q <= R_OK;
          else if (sz_q == 2'd2) begin
            resp_q <= {1'b0, mem_rdata[31:16]};
            lo_q   <= mem_rdata[15:0];
            state  <= ST_RESHI;
          end
          else if (sz_q == 2'd1)  resp_q <= {1'b0, mem_rdata[15:0]};
          else                    resp_q <= {9'h0, mem_rdata[7:0]};
        end
      end else if (xfer_valid) begin
        case (state)
          ST_RESHI: begin
            resp_q <= {1'b0, lo_q};
            state  <= ST_CMD;
          end
          ST_OPND: begin
            sr  <= xfer_in;
            got <= got + 2'd1;
            if (got == 2'd1) addr_lat <= lword;
            if (last) begin
              state  <= ST_CMD;
              resp_q <= R_OK;
              case (op_q)
                OP_WREG: regs[ix_q] <= lword;
                OP_WSYS: sys[ix_q[1:0]] <= lword;
                OP_READ: begin
                  mem_req <= 1'b1; mem_we <= 1'b0; mem_size <= sz_q; mem_fc <= sys[0][2:0];
                  mem_addr <= lword; rd_ptr <= lword;
                  state <= ST_BUSY; resp_q <= R_NR;
                end
                OP_WRITE: begin
                  mem_req <= 1'b1; mem_we <= 1'b1; mem_size <= sz_q; mem_fc <= sys[1][2:0];
                  mem_addr <= addr_lat; wr_ptr <= addr_lat; mem_wdata <= wdat;
                  state <= ST_BUSY; resp_q <= R_NR;
                end
                default: begin
                  mem_req <= 1'b1; mem_we <= 1'b1; mem_size <= sz_q; mem_fc <= sys[1][2:0];
                  mem_addr <= wr_ptr + inc_q; wr_ptr <= wr_ptr + inc_q; mem_wdata <= wdat;
                  state <= ST_BUSY; resp_q <= R_NR;
                end
              endcase
            end else begin
              resp_q <= R_NR;
            end
          end
          default: begin
            op_q <= c_op;
            sz_q <= c_sz;
            ix_q <= xfer_in[3:0];
            got  <= '0;
            resp_q <= R_OK;
            case (c_op)
              OP_NOP: ;
              OP_RREG: begin
                resp_q <= {1'b0, regs[xfer_in[3:0]][31:16]};
                lo_q   <= regs[xfer_in[3:0]][15:0];
                state  <= ST_RESHI;
              end
              OP_RSYS: begin
                resp_q <= {1'b0, sys[xfer_in[1:0]][31:16]};
                lo_q   <= sys[xfer_in[1:0]][15:0];
                state  <= ST_RESHI;
              end
              OP_WREG, OP_WSYS: begin
                need <= 3'd2; state <= ST_OPND; resp_q <= R_NR;
              end
              OP_READ, OP_WRITE, OP_FILL, OP_DUMP: begin
                if (c_sz == 2'd3) resp_q <= R_ILL;
                else if (c_op == OP_DUMP) begin
                  mem_req <= 1'b1; mem_we <= 1'b0; mem_size <= c_sz; mem_fc <= sys[0][2:0];
                  mem_addr <= rd_ptr + inc_c; rd_ptr <= rd_ptr + inc_c;
                  state <= ST_BUSY; resp_q <= R_NR;
                end else begin
                  state <= ST_OPND; resp_q <= R_NR;
                  if (c_op == OP_READ)       need <= 3'd2;
                  else if (c_op == OP_WRITE) need <= (c_sz == 2'd2) ? 3'd4 : 3'd3;
                  else                       need <= (c_sz == 2'd2) ? 3'd2 : 3'd1;
                end
              end
              OP_GO, OP_CALL: begin
                exit_pulse <= 1'b1;
                exit_call  <= (c_op == OP_CALL);
              end
              OP_RST: rst_cnt <= CW'(RST_CYCLES);
              default: resp_q <= R_ILL;
            endcase
          end
        endcase
      end
    end
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !mem_berr |=> mem_req && $stable(mem_addr) && $stable(mem_fc));
  assert_rdfc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && !mem_we |-> mem_fc == sys[0][2:0]);
  assert_busy_nr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && xfer_valid |-> resp_out == R_NR);
  assert_berr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_berr |=> resp_out == R_BERR);
  assert_rst_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(periph_rst) |-> $past(xfer_valid && state == ST_CMD && xfer_in[15:12] == OP_RST));
  assert_exit_src_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exit_pulse) |-> $past(xfer_valid && state == ST_CMD && (xfer_in[15:12] == OP_GO || xfer_in[15:12] == OP_CALL)));
endmodule

// File: tb/dbg_cmd_seq_tb.sv
module dbg_cmd_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 8;
  localparam logic [16:0] OK = 17'h0FFFF, NR = 17'h10000, ILL = 17'h1FFFF, BE = 17'h10001;

  logic clk = 1'b0, rst_n = 1'b0, xfer_valid = 1'b0;
  logic [15:0] xfer_in = '0;
  logic [16:0] resp_out;
  logic mem_req, mem_we, periph_rst, exit_pulse, exit_call;
  logic [1:0] mem_size;
  logic [2:0] mem_fc;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic mem_ack = 1'b0, mem_berr = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_cmd_seq u_dut (.clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_in(xfer_in),
    .resp_out(resp_out), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_fc(mem_fc), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_berr(mem_berr), .periph_rst(periph_rst),
    .exit_pulse(exit_pulse), .exit_call(exit_call));

  int n_cmp = 0, n_bad = 0;
  logic [16:0] exp_q[$];
  string tag_q[$];

  logic [7:0] mm [256];
  logic [7:0] gold [256];
  int lat = 2, cnt = 0;
  logic [2:0] last_fc = '0;
  int rst_hi = 0, exits = 0;
  logic last_call = 1'b0;

  always @(posedge clk) begin
    if (mem_ack || mem_berr) begin
      mem_ack <= 1'b0; mem_berr <= 1'b0;
    end else if (mem_req) begin
      if (cnt >= lat) begin
        logic [7:0] a;
        a = mem_addr[7:0];
        cnt = 0;
        last_fc <= mem_fc;
        if (mem_addr[31:28] == 4'hE) mem_berr <= 1'b1;
        else begin
          mem_ack <= 1'b1;
          if (mem_we) begin
            case (mem_size)
              2'd2: begin mm[a] = mem_wdata[31:24]; mm[a+8'd1] = mem_wdata[23:16];
                          mm[a+8'd2] = mem_wdata[15:8]; mm[a+8'd3] = mem_wdata[7:0]; end
              2'd1: begin mm[a] = mem_wdata[15:8]; mm[a+8'd1] = mem_wdata[7:0]; end
              default: mm[a] = mem_wdata[7:0];
            endcase
          end else begin
            case (mem_size)
              2'd2: mem_rdata <= {mm[a], mm[a+8'd1], mm[a+8'd2], mm[a+8'd3]};
              2'd1: mem_rdata <= {16'h0, mm[a], mm[a+8'd1]};
              default: mem_rdata <= {24'h0, mm[a]};
            endcase
          end
        end
      end else cnt = cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (periph_rst) rst_hi++;
    if (exit_pulse) begin exits++; last_call = exit_call; end
  end

  always begin
    @(negedge clk); #1;
    if (xfer_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard empty: actual %h expected none", resp_out);
      end else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (resp_out !== e) begin
          n_bad++;
          $display("FAIL %s: resp actual %h expected %h", t, resp_out, e);
        end
      end
    end
  end

  task automatic xf(input logic [15:0] w, input logic [16:0] e, input string t);
    @(negedge clk);
    xfer_in = w; xfer_valid = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    xfer_valid = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] e);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  function automatic logic [15:0] C(input logic [3:0] op, input logic [1:0] sz, input logic [3:0] ix);
    return {op, 4'h0, sz, 2'b00, ix};
  endfunction

  function automatic logic [16:0] D(input logic [15:0] v);
    return {1'b0, v};
  endfunction

  localparam logic [15:0] NOP = 16'h0000;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mm[i] = 8'((i * 7 + 3) & 255);
      gold[i] = mm[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 resp", 32'(resp_out), 32'(OK));
    chk("R1 idle", {29'h0, mem_req, periph_rst, exit_pulse}, 32'h0);
    xf(NOP, OK, "R1");
    xf(NOP, OK, "R2");
    // R3 data register 3 and address register 10
    xf(C(2, 2, 3), OK, "R2");
    xf(16'h1234, NR, "R3");
    xf(16'h5678, NR, "R3");
    xf(C(2, 2, 10), OK, "R3");
    xf(16'hA5A5, NR, "R3");
    xf(16'h0F0F, NR, "R3");
    xf(C(1, 2, 3), OK, "R3");
    xf(16'hF000, D(16'h1234), "R3");
    xf(C(1, 2, 10), D(16'h5678), "R3");
    xf(NOP, D(16'hA5A5), "R3");
    xf(NOP, D(16'h0F0F), "R3");
    // R4 function-code registers
    xf(C(4, 2, 0), OK, "R4");
    xf(16'h0000, NR, "R4");
    xf(16'h0005, NR, "R4");
    xf(C(4, 2, 1), OK, "R4");
    xf(16'h0000, NR, "R4");
    xf(16'h0003, NR, "R4");
    xf(C(3, 2, 1), OK, "R4");
    xf(NOP, D(16'h0000), "R4");
    xf(NOP, D(16'h0003), "R4");
    // R6 long write
    xf(C(6, 2, 0), OK, "R6");
    xf(16'h0000, NR, "R6");
    xf(16'h0010, NR, "R6");
    xf(16'hCAFE, NR, "R6");
    xf(16'hBABE, NR, "R6");
    gold[8'h10] = 8'hCA; gold[8'h11] = 8'hFE; gold[8'h12] = 8'hBA; gold[8'h13] = 8'hBE;
    chk("R6 dest fc", 32'(last_fc), 32'd3);
    xf(NOP, OK, "R6");
    // R5 long read
    xf(C(5, 2, 0), OK, "R5");
    xf(16'h0000, NR, "R5");
    xf(16'h0010, NR, "R5");
    chk("R5 src fc", 32'(last_fc), 32'd5);
    xf(NOP, D(16'hCAFE), "R5");
    xf(NOP, D(16'hBABE), "R5");
    // R6 word write then R11 fills
    xf(C(6, 1, 0), OK, "R6");
    xf(16'h0000, NR, "R6");
    xf(16'h0020, NR, "R6");
    xf(16'h1111, NR, "R6");
    gold[8'h20] = 8'h11; gold[8'h21] = 8'h11;
    xf(C(8, 1, 0), OK, "R11");
    xf(16'h2222, NR, "R11");
    gold[8'h22] = 8'h22; gold[8'h23] = 8'h22;
    xf(C(8, 1, 0), OK, "R11");
    xf(16'h3333, NR, "R11");
    gold[8'h24] = 8'h33; gold[8'h25] = 8'h33;
    xf(C(8, 0, 0), OK, "R11");
    xf(16'h7744, NR, "R11");
    gold[8'h25] = 8'h44;
    // R10 dumps after a word read
    xf(C(5, 1, 0), OK, "R11");
    xf(16'h0000, NR, "R10");
    xf(16'h0020, NR, "R10");
    xf(C(7, 1, 0), D({gold[8'h20], gold[8'h21]}), "R10");
    xf(C(7, 1, 0), D({gold[8'h22], gold[8'h23]}), "R10");
    xf(C(7, 2, 0), D({gold[8'h24], gold[8'h25]}), "R10");
    xf(NOP, D({gold[8'h28], gold[8'h29]}), "R10");
    xf(NOP, D({gold[8'h2A], gold[8'h2B]}), "R10");
    // R5 byte read
    xf(C(5, 0, 0), OK, "R5");
    xf(16'h0000, NR, "R5");
    xf(16'h0025, NR, "R5");
    xf(NOP, D({8'h00, gold[8'h25]}), "R5");
    // R8 illegal opcode and illegal size
    xf(16'hF000, OK, "R8");
    xf(C(5, 3, 0), ILL, "R8");
    xf(NOP, ILL, "R8");
    xf(NOP, OK, "R8");
    // R7 not-ready while busy, word discarded
    lat = 20;
    xf(C(5, 1, 0), OK, "R7");
    xf(16'h0000, NR, "R7");
    xf(16'h0020, NR, "R7");
    xf(16'hF000, NR, "R7");
    repeat (30) @(negedge clk);
    lat = 2;
    xf(NOP, D({gold[8'h20], gold[8'h21]}), "R7");
    xf(NOP, OK, "R7");
    // R9 bus error drops the low result word
    xf(C(5, 2, 0), OK, "R9");
    xf(16'hE000, NR, "R9");
    xf(16'h0000, NR, "R9");
    xf(NOP, BE, "R9");
    xf(NOP, OK, "R9");
    // R12 peripheral reset
    xf(C(11, 0, 0), OK, "R12");
    chk("R12 high", 32'(periph_rst), 32'd1);
    xf(NOP, OK, "R12");
    repeat (600) @(negedge clk);
    chk("R12 length", 32'(rst_hi), 32'd512);
    // R13 exit strobes
    xf(C(9, 0, 0), OK, "R13");
    chk("R13 go count", 32'(exits), 32'd1);
    chk("R13 go flag", 32'(last_call), 32'd0);
    xf(C(10, 0, 0), OK, "R13");
    chk("R13 call count", 32'(exits), 32'd2);
    chk("R13 call flag", 32'(last_call), 32'd1);
    xf(NOP, OK, "R13");
    chk("R13 no extra", 32'(exits), 32'd2);
    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'd0);
    summary();
  end
endmodule